// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Refresh Timer

This block brings a single-rank, 16-bit, four-bank SDR SDRAM (13 row bits, 9 column bits, 32 MiB) from reset to an operational state. Only the command pins are driven. After reset it keeps every pin quiet for a programmable settling time. It then enables the device clock and runs a fixed command script: a NOP, a precharge of all banks, two auto-refreshes, a mode-register load and a low-power extended mode load. The gap between successive commands is set in clock cycles by elaboration parameters.

When the last mode load has settled, the block raises a completion flag and hands over to a refresh timer. The timer issues an auto-refresh at a fixed interval, which is derived from the configured clock frequency and the refresh period in nanoseconds. All outputs are registered. A controller that owns the data path can take the pins once the flag is high. It only has to make room for the refresh slots.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, and afterwards until the first NOP, CKE is low and the pins are held at NOP ({cs_n,ras_n,cas_n,we_n} = 0111). BA is 0, A is 0 and init_done is low.
- R2: PWRUP_CYC = CLK_HZ*PWRUP_NS/10^9 (50000 with the defaults). On the PWRUP_CYC-th rising edge after reset is released, CKE goes high and a NOP is driven in the same cycle. CKE then stays high.
- R3: One cycle after that NOP, a precharge-all (0010) appears with A10 = 1. All other address bits are 0 and BA is 0.
- R4: The first auto-refresh (0001) comes T_RP cycles after the precharge. The second comes T_RC cycles after the first.
- R5: A mode-register load (0000) comes T_RC cycles after the second refresh. It carries BA = 00, A[2:0] = log2(burst length), A3 = 0 (sequential), A[6:4] = CAS latency and all other bits 0.
- R6: An extended mode load (0000) comes T_MRD cycles after the mode load. It carries BA = 10 (BA1 high, BA0 low), A[2:0] = partial-array field, A[4:3] = temperature-compensation field, A[6:5] = drive-strength field and all other bits 0.
- R7: init_done rises T_MRD cycles after the extended mode load and stays high.
- R8: REF_CYC = CLK_HZ*REFI_NS/10^9 (3906 at 250 MHz and 15625 ns). The first auto-refresh comes REF_CYC cycles after init_done rises, and every REF_CYC cycles after that. While init_done is high, no other command appears.
- R9: Each command lasts exactly one cycle. Between commands the pins carry NOP with BA and A at 0, and only the four encodings above ever appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the SDRAM clock domain |
| rst | input | 1 | Synchronous active-high reset |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W (2) | Bank address |
| addr_o | output | ADDR_W (13) | Row/column/mode address |
| init_done_o | output | 1 | High once the power-up script has finished |

## Verification
The refresh cadence is the hardest thing to observe from the ports. It is visible only after the full settling wait and the whole command script, and the first refresh timing depends on the exact cycle in which init_done rose. The bench runs the complete default-frequency power-up of more than fifty thousand cycles and timestamps every pin change. It then measures three successive refresh intervals against the arithmetic interval. Non-zero burst-length, CAS, partial-array, temperature and drive values are used so that each mode-load field lands in a distinct, checkable position.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_PRE,
    ST_REF1,
    ST_REF2,
    ST_MODE,
    ST_EXT,
    ST_SETTLE,
    ST_RUN
  } boot_step_e;

  localparam int ALL_BANK_BIT = 10;

  function automatic int ns_to_cycles(longint unsigned hz, longint unsigned ns);
    return int'((hz * ns) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
  parameter int W     = 16,
  parameter int START = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= W'(START);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
  import sdram_boot_pkg::*;
#(
  parameter int W         = 16,
  parameter int PWRUP_CYC = 50000,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_MRD     = 2,
  parameter int REF_CYC   = 3906
) (
  input  logic    clk,
  input  logic    rst,
  output sd_cmd_e issue_cmd,
  output logic    issue_ext,
  output logic    cke_q,
  output logic    done_q
);

  boot_step_e   step_q, step_d;
  logic         load;
  logic [W-1:0] load_val;
  logic         expired;

  // One shared down-counter times every gap, including the settle wait.
  sdram_gap_counter #(
    .W     (W),
    .START (PWRUP_CYC - 1)
  ) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    step_d    = step_q;
    issue_cmd = CMD_NOP;
    issue_ext = 1'b0;
    load      = 1'b0;
    load_val  = '0;
    if (expired) begin
      load = 1'b1;
      unique case (step_q)
        ST_POWER: begin
          load_val = '0;
          step_d   = ST_PRE;
        end
        ST_PRE: begin
          issue_cmd = CMD_PRE;
          load_val  = W'(T_RP - 1);
          step_d    = ST_REF1;
        end
        ST_REF1: begin
          issue_cmd = CMD_AREF;
          load_val  = W'(T_RC - 1);
          step_d    = ST_REF2;
        end
        ST_REF2: begin
          issue_cmd = CMD_AREF;
          load_val  = W'(T_RC - 1);
          step_d    = ST_MODE;
        end
        ST_MODE: begin
          issue_cmd = CMD_LMR;
          load_val  = W'(T_MRD - 1);
          step_d    = ST_EXT;
        end
        ST_EXT: begin
          issue_cmd = CMD_LMR;
          issue_ext = 1'b1;
          load_val  = W'(T_MRD - 1);
          step_d    = ST_SETTLE;
        end
        ST_SETTLE: begin
          load_val = W'(REF_CYC - 1);
          step_d   = ST_RUN;
        end
        ST_RUN: begin
          issue_cmd = CMD_AREF;
          load_val  = W'(REF_CYC - 1);
        end
        default: begin
          load_val = '0;
          step_d   = ST_POWER;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_POWER;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      if (expired && step_q == ST_POWER)  cke_q  <= 1'b1;
      if (expired && step_q == ST_SETTLE) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_mode_words.sv
module sdram_mode_words #(
  parameter int ADDR_W       = 13,
  parameter int BURST_LEN    = 1,
  parameter int CAS_LAT      = 2,
  parameter int WRITE_SINGLE = 0,
  parameter int PASR         = 0,
  parameter int TCSR         = 0,
  parameter int DRV          = 0
) (
  output logic [ADDR_W-1:0] mrs_word,
  output logic [ADDR_W-1:0] emrs_word
);

  localparam int BL_CODE = (BURST_LEN <= 1) ? 0 : $clog2(BURST_LEN);

  always_comb begin
    mrs_word      = '0;
    mrs_word[2:0] = 3'(BL_CODE);
    mrs_word[3]   = 1'b0;
    mrs_word[6:4] = 3'(CAS_LAT);
    mrs_word[9]   = 1'(WRITE_SINGLE);

    emrs_word      = '0;
    emrs_word[2:0] = 3'(PASR);
    emrs_word[4:3] = 2'(TCSR);
    emrs_word[6:5] = 2'(DRV);
  end

endmodule

// File: rtl/sdram_pin_stage.sv
module sdram_pin_stage
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sd_cmd_e           issue_cmd,
  input  logic              issue_ext,
  input  logic [ADDR_W-1:0] mrs_word,
  input  logic [ADDR_W-1:0] emrs_word,
  output logic [3:0]        cmd_q,
  output logic [BANK_W-1:0] ba_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic [BANK_W-1:0] ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    ba_d   = '0;
    addr_d = '0;
    unique case (issue_cmd)
      CMD_PRE: addr_d[ALL_BANK_BIT] = 1'b1;
      CMD_LMR: begin
        if (issue_ext) begin
          ba_d   = BANK_W'(2);
          addr_d = emrs_word;
        end else begin
          addr_d = mrs_word;
        end
      end
      default: begin
        ba_d   = '0;
        addr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= issue_cmd;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 250_000_000,
  parameter int unsigned PWRUP_NS     = 200_000,
  parameter int unsigned REFI_NS      = 15_625,
  parameter int          T_RP         = 3,
  parameter int          T_RC         = 9,
  parameter int          T_MRD        = 2,
  parameter int          BURST_LEN    = 1,
  parameter int          CAS_LAT      = 2,
  parameter int          WRITE_SINGLE = 0,
  parameter int          PASR         = 0,
  parameter int          TCSR         = 0,
  parameter int          DRV          = 0,
  parameter int          ADDR_W       = 13,
  parameter int          BANK_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int PWRUP_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(PWRUP_NS));
  localparam int REF_CYC   = ns_to_cycles(longint'(CLK_HZ), longint'(REFI_NS));
  localparam int MAX_GAP   = (PWRUP_CYC > REF_CYC) ? PWRUP_CYC : REF_CYC;
  localparam int CNT_W     = $clog2(MAX_GAP + 1);

  sd_cmd_e           issue_cmd;
  logic              issue_ext;
  logic              cke_q;
  logic              done_q;
  logic [ADDR_W-1:0] mrs_word;
  logic [ADDR_W-1:0] emrs_word;
  logic [3:0]        cmd_q;

  sdram_boot_fsm #(
    .W         (CNT_W),
    .PWRUP_CYC (PWRUP_CYC),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_MRD     (T_MRD),
    .REF_CYC   (REF_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .issue_cmd (issue_cmd),
    .issue_ext (issue_ext),
    .cke_q     (cke_q),
    .done_q    (done_q)
  );

  sdram_mode_words #(
    .ADDR_W       (ADDR_W),
    .BURST_LEN    (BURST_LEN),
    .CAS_LAT      (CAS_LAT),
    .WRITE_SINGLE (WRITE_SINGLE),
    .PASR         (PASR),
    .TCSR         (TCSR),
    .DRV          (DRV)
  ) u_words (
    .mrs_word  (mrs_word),
    .emrs_word (emrs_word)
  );

  sdram_pin_stage #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .issue_cmd (issue_cmd),
    .issue_ext (issue_ext),
    .mrs_word  (mrs_word),
    .emrs_word (emrs_word),
    .cmd_q     (cmd_q),
    .ba_q      (ba_o),
    .addr_q    (addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign cke_o       = cke_q;
  assign init_done_o = done_q;

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
  parameter int ADDR_W  = 13,
  parameter int BANK_W  = 2,
  parameter int REF_CYC = 3906
) (
  input logic              clk,
  input logic              rst,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              init_done_o
);

  localparam int GW = $clog2(REF_CYC + 2);

  logic [3:0]    cmd4;
  logic [GW-1:0] gap_q;

  assign cmd4 = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  // Cycles since init_done rose or since the latest refresh.
  always_ff @(posedge clk) begin
    if (rst || !init_done_o) begin
      gap_q <= '0;
    end else if (cmd4 == 4'b0001) begin
      gap_q <= GW'(1);
    end else if (gap_q != GW'(REF_CYC + 1)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  a_r1_quiet_before_cke: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> (cmd4 == 4'b0111 && ba_o == '0 && addr_o == '0 && !init_done_o));

  a_r2_cke_holds: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o);

  a_r3_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (cmd4 == 4'b0010) |-> (addr_o[10] && ba_o == '0));

  a_r6_mode_bank: assert property (@(posedge clk) disable iff (rst)
    (cmd4 == 4'b0000) |-> (ba_o == BANK_W'(0) || ba_o == BANK_W'(2)));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
    init_done_o |=> init_done_o);

  a_r8_only_refresh: assert property (@(posedge clk) disable iff (rst)
    (init_done_o && cmd4 != 4'b0111) |-> (cmd4 == 4'b0001));

  a_r8_refresh_period: assert property (@(posedge clk) disable iff (rst)
    (init_done_o && cmd4 == 4'b0001) |-> (gap_q == GW'(REF_CYC)));

  a_r8_no_late_refresh: assert property (@(posedge clk) disable iff (rst)
    init_done_o |-> (gap_q <= GW'(REF_CYC)));

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (cmd4 != 4'b0111) |=> (cmd4 == 4'b0111));

  a_r9_known_code: assert property (@(posedge clk) disable iff (rst)
    (cmd4 == 4'b0111 || cmd4 == 4'b0010 || cmd4 == 4'b0001 || cmd4 == 4'b0000));

endmodule

bind sdram_boot_seq sdram_boot_chk #(
  .ADDR_W  (ADDR_W),
  .BANK_W  (BANK_W),
  .REF_CYC (REF_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cke_o       (cke_o),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .init_done_o (init_done_o)
);

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;

  localparam longint HZ     = 250_000_000;
  localparam longint PW_NS  = 200_000;
  localparam longint RF_NS  = 15_625;
  localparam int     TRP    = 3;
  localparam int     TRC    = 9;
  localparam int     TMRD   = 2;
  localparam int     BL     = 4;
  localparam int     CL     = 3;
  localparam int     PA     = 2;
  localparam int     TC     = 1;
  localparam int     DS     = 1;
  localparam int     NEV    = 8;
  localparam int     LIMIT  = 200_000;

  localparam int PWR  = int'(HZ * PW_NS / 1_000_000_000);
  localparam int REF  = int'(HZ * RF_NS / 1_000_000_000);
  localparam int MRSV = $clog2(BL) + (CL << 4);
  localparam int EMRV = PA + (TC << 3) + (DS << 5);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #2 clk = ~clk;

  sdram_boot_seq #(
    .CLK_HZ    (250_000_000),
    .PWRUP_NS  (200_000),
    .REFI_NS   (15_625),
    .T_RP      (TRP),
    .T_RC      (TRC),
    .T_MRD     (TMRD),
    .BURST_LEN (BL),
    .CAS_LAT   (CL),
    .PASR      (PA),
    .TCSR      (TC),
    .DRV       (DS)
  ) i_sdram_boot_seq (
    .clk         (clk),
    .rst         (rst),
    .cke_o       (cke),
    .cs_n_o      (cs_n),
    .ras_n_o     (ras_n),
    .cas_n_o     (cas_n),
    .we_n_o      (we_n),
    .ba_o        (ba),
    .addr_o      (addr),
    .init_done_o (done)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int     ev_cyc  [NEV];
  int     ev_cmd  [NEV];
  int     ev_ba   [NEV];
  int     ev_addr [NEV];
  int     exp_cyc [NEV];
  int     exp_cmd [NEV];
  string  tag     [NEV] = '{"R3", "R4", "R4", "R5", "R6", "R8", "R8", "R8"};

  initial begin
    int  cyc = 0;
    int  n_ev = 0;
    int  cke_cyc = -1;
    int  done_cyc = -1;
    int  nop_at_cke = 0;
    int  static_bad = 0;
    int  cke_drop = 0;
    int  done_drop = 0;
    int  dirty_nop = 0;
    int  bad_code = 0;
    int  back2back = 0;
    bit  prev_cmd = 1'b0;
    logic [3:0] c4;

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(cke == 1'b0, "R1", "cke in reset", cke, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "cmd in reset",
          {cs_n, ras_n, cas_n, we_n}, 7);
    check(ba == 2'd0 && addr == 13'd0, "R1", "addr in reset", addr, 0);
    check(done == 1'b0, "R1", "init_done in reset", done, 0);
    rst = 1'b0;

    while (n_ev < NEV && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      c4 = {cs_n, ras_n, cas_n, we_n};
      if (cke_cyc < 0) begin
        if (cke) begin
          cke_cyc    = cyc;
          nop_at_cke = (c4 == 4'b0111) ? 1 : 0;
        end else if (c4 != 4'b0111 || ba != 2'd0 || addr != 13'd0 || done) begin
          static_bad++;
        end
      end else if (!cke) begin
        cke_drop++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      if (!done && done_cyc >= 0) done_drop++;
      if (c4 != 4'b0111 && c4 != 4'b0010 && c4 != 4'b0001 && c4 != 4'b0000) bad_code++;
      if (c4 != 4'b0111) begin
        if (prev_cmd) back2back++;
        ev_cyc[n_ev]  = cyc;
        ev_cmd[n_ev]  = int'(c4);
        ev_ba[n_ev]   = int'(ba);
        ev_addr[n_ev] = int'(addr);
        n_ev++;
        prev_cmd = 1'b1;
      end else begin
        prev_cmd = 1'b0;
        if (ba != 2'd0 || addr != 13'd0) dirty_nop++;
      end
    end

    check(cyc < LIMIT, "R8", "watchdog expired before all commands", cyc, LIMIT);

    // expected schedule
    exp_cyc[0] = PWR + 1;
    exp_cyc[1] = exp_cyc[0] + TRP;
    exp_cyc[2] = exp_cyc[1] + TRC;
    exp_cyc[3] = exp_cyc[2] + TRC;
    exp_cyc[4] = exp_cyc[3] + TMRD;
    for (int i = 5; i < NEV; i++) exp_cyc[i] = exp_cyc[4] + TMRD + (i - 4) * REF;
    exp_cmd = '{2, 1, 1, 0, 0, 1, 1, 1};

    check(static_bad == 0, "R1", "pin changes before power-up wait", static_bad, 0);
    check(cke_cyc == PWR, "R2", "cke rise cycle", cke_cyc, PWR);
    check(nop_at_cke == 1, "R2", "NOP with cke", nop_at_cke, 1);
    check(cke_drop == 0, "R2", "cke drops", cke_drop, 0);
    check(done_cyc == exp_cyc[4] + TMRD, "R7", "init_done rise cycle",
          done_cyc, exp_cyc[4] + TMRD);
    check(done_drop == 0, "R7", "init_done drops", done_drop, 0);

    for (int i = 0; i < NEV; i++) begin
      if (i < n_ev) begin
        check(ev_cmd[i] == exp_cmd[i], tag[i], $sformatf("command %0d code", i),
              ev_cmd[i], exp_cmd[i]);
        check(ev_cyc[i] == exp_cyc[i], tag[i], $sformatf("command %0d cycle", i),
              ev_cyc[i], exp_cyc[i]);
      end
    end
    // R3: precharge-all address
    check(ev_addr[0] == 13'h400 && ev_ba[0] == 0, "R3", "precharge address", ev_addr[0], 13'h400);
    // R5: mode load fields
    check(ev_ba[3] == 0, "R5", "mode load bank", ev_ba[3], 0);
    check(ev_addr[3] == MRSV, "R5", "mode load address", ev_addr[3], MRSV);
    // R6: extended load fields
    check(ev_ba[4] == 2, "R6", "extended load bank", ev_ba[4], 2);
    check(ev_addr[4] == EMRV, "R6", "extended load address", ev_addr[4], EMRV);
    // R8: refresh intervals
    check(ev_cyc[5] - done_cyc == REF, "R8", "first refresh after done",
          ev_cyc[5] - done_cyc, REF);
    for (int i = 6; i < NEV; i++)
      check(ev_cyc[i] - ev_cyc[i-1] == REF, "R8", "refresh interval",
            ev_cyc[i] - ev_cyc[i-1], REF);
    // R9: single-cycle commands and clean NOPs
    check(back2back == 0, "R9", "back-to-back commands", back2back, 0);
    check(dirty_nop == 0, "R9", "NOP with non-zero address", dirty_nop, 0);
    check(bad_code == 0, "R9", "unknown encodings", bad_code, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule